// File: doc/BRIEF.md
# Receive Byte Packing FIFO

This block sits between the character output of a serial receiver and a bus master that copies received data into memory buffers. Each received byte enters through a one-cycle write strobe. The block stores it and offers it to the consumer on a valid/ready read port. Two width modes are available. In wide mode, bytes are gathered four at a time into 32-bit words, and a four-word store holds sixteen bytes. In narrow mode, every byte is offered on its own as soon as it arrives, and the same four entries each carry a single byte, so the usable storage falls to one quarter.

An end-of-frame strobe pushes out a partially gathered word in wide mode. A valid-byte count comes with that word. When a byte arrives and the store has no free entry, the byte is discarded and a sticky overflow flag is raised. The requested mode is sampled at all times, but it takes effect only once the block holds no data at all. Two level outputs report the number of store entries in use and the number of bytes waiting in the gathering register.

Top module: `rx_pack_fifo`

## Requirements
- R1: After reset, rd_valid_o, level_o, partial_o and ovf_o are 0, and rd_wide_o is 1 (wide mode).
- R2: In wide mode, four accepted bytes form one word, with the earliest byte in bits [7:0] and the latest in bits [31:24]. rd_valid_o stays 0 until the fourth byte is taken. A complete word shows rd_cnt_o = 0, which means all four bytes are valid.
- R3: In wide mode, the store holds four words. A byte written while level_o = 4 is discarded, leaves partial_o unchanged and sets ovf_o.
- R4: In narrow mode (rd_wide_o = 0), a byte written on one clock edge is offered after that edge. It sits in bits [7:0] with bits [31:8] zero and rd_cnt_o = 1.
- R5: In narrow mode, at most four bytes are held. A fifth byte written while four are held is discarded and sets ovf_o. The held bytes are read out in arrival order.
- R6: In wide mode, eof_i pushes the gathered bytes out as one word. A byte written in the same cycle as eof_i is included. The unused upper bytes read as zero, and rd_cnt_o gives the number of valid bytes (1 to 3, or 0 for four). After the push, partial_o returns to 0.
- R7: ovf_o stays at 1 until ovf_clr_i is asserted. If a discard and ovf_clr_i fall in the same cycle, ovf_o stays 1.
- R8: A change on narrow_i takes effect only on a clock edge where level_o = 0, partial_o = 0 and no byte is being accepted. Until then rd_wide_o keeps the old mode.
- R9: An entry is removed only on an edge where rd_valid_o and rd_ready_i are both 1. While rd_valid_o = 1 and rd_ready_i = 0, rd_data_o and rd_cnt_o hold steady.
- R10: level_o counts the occupied store entries (0 to 4), and partial_o counts the bytes held in the gathering register (0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow_i | input | 1 | Requested mode: 1 = byte-at-a-time, 0 = 32-bit packing |
| wr_valid_i | input | 1 | A received byte is present this cycle |
| wr_byte_i | input | 8 | Received byte |
| eof_i | input | 1 | Frame end: push out the partial word (wide mode) |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| rd_valid_o | output | 1 | Head entry available |
| rd_ready_i | input | 1 | Consumer accepts the head entry |
| rd_data_o | output | 32 | Head entry data, little-endian byte lanes |
| rd_cnt_o | output | 2 | Valid bytes in the head entry, 0 meaning four |
| rd_wide_o | output | 1 | 1 when the active mode is 32-bit packing |
| level_o | output | 3 | Occupied store entries |
| partial_o | output | 2 | Bytes in the gathering register |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that rd_ready_i is driven only as a plain accept signal, and that the consumer may raise it whether or not data is present, so no property depends on ready being held. They also assume that reset is held for at least one edge before any property is evaluated. The bench changes every input only at falling edges and pulses the write strobe for exactly one cycle per byte. It flips narrow_i while a partial word is still held, so that the deferred mode change is exercised without any input ever being undefined.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  typedef enum logic {
    MODE_WIDE   = 1'b0,
    MODE_NARROW = 1'b1
  } rxp_mode_e;
endpackage

// File: rtl/rxp_store.sv
module rxp_store #(
  parameter int DW    = 34,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o,
  output logic          full_o
);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (push_i) mem[wp_q] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_i) wp_q <= wp_q + 1'b1;
      if (pop_i)  rp_q <= rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign head_o  = mem[rp_q];
  assign level_o = lvl_q;
  assign full_o  = (lvl_q == LVL_FULL);

  // R3 / R5: the packer never pushes into a full store
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (rst)
    full_o |-> !push_i);
  // R9: a removal needs an occupied entry
  p_no_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
    (lvl_q == '0) |-> !pop_i);
  // R10: the level never exceeds the depth
  p_level_bound_r10: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= LVL_FULL);
endmodule

// File: rtl/rxp_packer.sv
module rxp_packer #(
  parameter int LANES = 4,
  localparam int WW = 8 * LANES,
  localparam int CW = $clog2(LANES),
  localparam int SW = CW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow_i,
  input  logic          full_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_byte_i,
  input  logic          eof_i,
  output logic          acc_o,
  output logic          push_o,
  output logic [WW-1:0] push_data_o,
  output logic [CW-1:0] push_cnt_o,
  output logic [CW-1:0] fill_o
);
  localparam logic [SW-1:0] SUM_FULL = SW'(LANES);

  logic [WW-1:0] pk_data_q, merged;
  logic [CW-1:0] pk_n_q;
  logic [SW-1:0] sum;

  assign acc_o = wr_valid_i && !full_i;
  assign sum   = {1'b0, pk_n_q} + SW'(acc_o);

  always_comb begin
    merged = pk_data_q;
    if (acc_o) merged[8*pk_n_q +: 8] = wr_byte_i;
  end

  always_comb begin
    if (narrow_i) begin
      push_o      = acc_o;
      push_data_o = {{(WW-8){1'b0}}, wr_byte_i};
      push_cnt_o  = CW'(1);
    end else begin
      push_o      = (sum == SUM_FULL) || (eof_i && !full_i && (sum != '0));
      push_data_o = merged;
      push_cnt_o  = sum[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pk_data_q <= '0;
      pk_n_q    <= '0;
    end else if (!narrow_i) begin
      if (push_o) begin
        pk_data_q <= '0;
        pk_n_q    <= '0;
      end else if (acc_o) begin
        pk_data_q <= merged;
        pk_n_q    <= sum[CW-1:0];
      end
    end
  end

  assign fill_o = pk_n_q;

  // R6: a partial word never coexists with a full store
  p_partial_room_r6: assert property (@(posedge clk) disable iff (rst)
    full_i |-> (pk_n_q == '0));
  // R4: narrow mode leaves the gathering register empty
  p_narrow_nofill_r4: assert property (@(posedge clk) disable iff (rst)
    narrow_i |-> (pk_n_q == '0));
endmodule

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo #(
  parameter int BYTES = 16,
  parameter int LANES = 4,
  localparam int DEPTH = BYTES / LANES,
  localparam int WW    = 8 * LANES,
  localparam int CW    = $clog2(LANES),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          narrow_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_byte_i,
  input  logic          eof_i,
  input  logic          ovf_clr_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [WW-1:0] rd_data_o,
  output logic [CW-1:0] rd_cnt_o,
  output logic          rd_wide_o,
  output logic [LW-1:0] level_o,
  output logic [CW-1:0] partial_o,
  output logic          ovf_o
);
  import rxp_pkg::*;

  rxp_mode_e     mode_q;
  logic          full, acc, push, pop, idle, ovf_q;
  logic [WW-1:0] push_data;
  logic [CW-1:0] push_cnt, fill;
  logic [WW+CW-1:0] head;

  rxp_packer #(.LANES(LANES)) u_packer (
    .clk(clk), .rst(rst),
    .narrow_i(mode_q == MODE_NARROW),
    .full_i(full),
    .wr_valid_i(wr_valid_i), .wr_byte_i(wr_byte_i), .eof_i(eof_i),
    .acc_o(acc), .push_o(push), .push_data_o(push_data),
    .push_cnt_o(push_cnt), .fill_o(fill)
  );

  rxp_store #(.DW(WW + CW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .push_i(push), .push_data_i({push_cnt, push_data}),
    .pop_i(pop),
    .head_o(head), .level_o(level_o), .full_o(full)
  );

  assign rd_valid_o = (level_o != '0);
  assign pop        = rd_valid_o && rd_ready_i;
  assign rd_data_o  = head[WW-1:0];
  assign rd_cnt_o   = head[WW+CW-1:WW];
  assign rd_wide_o  = (mode_q == MODE_WIDE);
  assign partial_o  = fill;
  assign ovf_o      = ovf_q;
  assign idle       = (level_o == '0) && (fill == '0) && !acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_WIDE;
      ovf_q  <= 1'b0;
    end else begin
      if (idle) mode_q <= narrow_i ? MODE_NARROW : MODE_WIDE;
      if (wr_valid_i && !acc) ovf_q <= 1'b1;
      else if (ovf_clr_i)     ovf_q <= 1'b0;
    end
  end

  // R8: the mode holds while any data is held
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((level_o != '0) || (fill != '0)) |=> $stable(mode_q));
  // R9: a stalled head keeps its contents
  p_head_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o) && $stable(rd_cnt_o)));
  // R7: a discarded byte raises the flag
  p_drop_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_i && !acc) |=> ovf_o);
  // R7: the flag only falls on a clear
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  // R4: narrow entries carry one byte in the low lane
  p_narrow_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_wide_o) |-> (rd_cnt_o == CW'(1) && rd_data_o[WW-1:8] == '0));
endmodule

// File: tb/rx_pack_fifo_tb.sv
module rx_pack_fifo_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        narrow_i = 1'b0, wr_valid_i = 1'b0, eof_i = 1'b0, ovf_clr_i = 1'b0;
  logic        rd_ready_i = 1'b0;
  logic [7:0]  wr_byte_i = '0;
  logic        rd_valid_o, rd_wide_o, ovf_o;
  logic [31:0] rd_data_o;
  logic [1:0]  rd_cnt_o, partial_o;
  logic [2:0]  level_o;
  int vec = 0, bad = 0;

  always #5 clk = ~clk;

  rx_pack_fifo u_dut (
    .clk(clk), .rst(rst), .narrow_i(narrow_i), .wr_valid_i(wr_valid_i),
    .wr_byte_i(wr_byte_i), .eof_i(eof_i), .ovf_clr_i(ovf_clr_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o),
    .rd_cnt_o(rd_cnt_o), .rd_wide_o(rd_wide_o), .level_o(level_o),
    .partial_o(partial_o), .ovf_o(ovf_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic eof);
    wr_valid_i = 1'b1; wr_byte_i = b; eof_i = eof;
    @(negedge clk);
    wr_valid_i = 1'b0; eof_i = 1'b0;
  endtask

  task automatic take(input string tag, input logic [31:0] d, input logic [1:0] c);
    check({tag, " valid"}, 32'(rd_valid_o), 32'd1);
    check({tag, " data"}, rd_data_o, d);
    check({tag, " cnt"}, 32'(rd_cnt_o), 32'(c));
    rd_ready_i = 1'b1;
    @(negedge clk);
    rd_ready_i = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(rd_valid_o), 0);
    check("R1 level", 32'(level_o), 0);
    check("R1 partial", 32'(partial_o), 0);
    check("R1 ovf", 32'(ovf_o), 0);
    check("R1 wide", 32'(rd_wide_o), 1);
  endtask

  task automatic t_wide_pack();
    put(8'h11, 0); put(8'h22, 0); put(8'h33, 0);
    check("R2 no early valid", 32'(rd_valid_o), 0);
    check("R10 partial 3", 32'(partial_o), 3);
    put(8'h44, 0);
    check("R10 level 1", 32'(level_o), 1);
    check("R10 partial 0", 32'(partial_o), 0);
    take("R2 word", 32'h44332211, 2'd0);
    check("R9 removed", 32'(level_o), 0);
  endtask

  task automatic t_wide_fill();
    for (int i = 0; i < 16; i++) put(8'(8'h10 + i), 0);
    check("R3 level 4", 32'(level_o), 4);
    check("R3 no ovf yet", 32'(ovf_o), 0);
    put(8'hEE, 0);
    check("R3 ovf set", 32'(ovf_o), 1);
    check("R3 partial kept", 32'(partial_o), 0);
    check("R3 level kept", 32'(level_o), 4);
    for (int w = 0; w < 4; w++) begin
      logic [7:0] b0;
      b0 = 8'(8'h10 + 4*w);
      take("R3 word", {8'(b0+3), 8'(b0+2), 8'(b0+1), b0}, 2'd0);
    end
    idle_cycles(1);
    check("R7 sticky", 32'(ovf_o), 1);
    ovf_clr_i = 1'b1; @(negedge clk); ovf_clr_i = 1'b0;
    check("R7 cleared", 32'(ovf_o), 0);
  endtask

  task automatic t_eof();
    put(8'hAA, 0); put(8'hBB, 1);
    check("R6 level", 32'(level_o), 1);
    check("R6 partial 0", 32'(partial_o), 0);
    take("R6 two bytes", 32'h0000BBAA, 2'd2);
    put(8'hC1, 0);
    eof_i = 1'b1; @(negedge clk); eof_i = 1'b0;
    take("R6 one byte", 32'h000000C1, 2'd1);
    eof_i = 1'b1; @(negedge clk); eof_i = 1'b0;
    check("R6 empty eof", 32'(level_o), 0);
  endtask

  task automatic t_mode_change();
    put(8'h5A, 0);
    narrow_i = 1'b1;
    idle_cycles(2);
    check("R8 held with partial", 32'(rd_wide_o), 1);
    eof_i = 1'b1; @(negedge clk); eof_i = 1'b0;
    check("R8 held with entry", 32'(rd_wide_o), 1);
    take("R8 last wide", 32'h0000005A, 2'd1);
    check("R8 not yet", 32'(rd_wide_o), 1);
    idle_cycles(1);
    check("R8 switched", 32'(rd_wide_o), 0);
  endtask

  task automatic t_narrow();
    put(8'h3C, 0);
    check("R4 immediate", 32'(rd_valid_o), 1);
    check("R4 data", rd_data_o, 32'h0000003C);
    check("R4 cnt", 32'(rd_cnt_o), 1);
    put(8'h4D, 0); put(8'h5E, 0); put(8'h6F, 0);
    check("R5 level 4", 32'(level_o), 4);
    ovf_clr_i = 1'b1;
    put(8'h77, 0);
    ovf_clr_i = 1'b0;
    check("R7 set wins", 32'(ovf_o), 1);
    check("R5 level kept", 32'(level_o), 4);
    take("R5 b0", 32'h3C, 2'd1);
    take("R5 b1", 32'h4D, 2'd1);
    take("R5 b2", 32'h5E, 2'd1);
    take("R5 b3", 32'h6F, 2'd1);
    check("R5 drained", 32'(rd_valid_o), 0);
    ovf_clr_i = 1'b1; @(negedge clk); ovf_clr_i = 1'b0;
    check("R7 clear narrow", 32'(ovf_o), 0);
  endtask

  task automatic t_handshake();
    rd_ready_i = 1'b1; @(negedge clk); rd_ready_i = 1'b0;
    check("R9 empty ready", 32'(level_o), 0);
    put(8'h81, 0); put(8'h92, 0);
    idle_cycles(3);
    check("R9 stall level", 32'(level_o), 2);
    check("R9 stall data", rd_data_o, 32'h81);
    take("R9 first", 32'h81, 2'd1);
    take("R9 second", 32'h92, 2'd1);
    narrow_i = 1'b0;
    idle_cycles(1);
    check("R8 back to wide", 32'(rd_wide_o), 1);
  endtask

  initial begin
    idle_cycles(3);
    rst = 1'b0;
    t_reset();
    t_wide_pack();
    t_wide_fill();
    t_eof();
    t_mode_change();
    t_narrow();
    t_handshake();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule